// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block holds the digital control for an 8-bit successive-approximation converter. Software writes a 3-bit clock-select code and raises a start request. The block then produces a conversion tick (one TAD period per tick) in one of two ways. It can divide the system clock by a ratio from 2 to 64. It can also take the rising edges of a separate RC clock input, which it synchronises into the system clock domain first. Once the first tick has arrived, the block runs a frame of ten tick periods.

During the frame it asserts a hold signal that disconnects the sampling capacitor from the input. It then resolves the result one bit per period, from the most significant bit down. For each bit it drives a trial code to an external DAC and reads back a single comparator bit. At the end of the frame it loads the result, drops busy, raises the sticky done flag and releases the hold.

Software can abort a conversion by clearing the start bit. An aborted conversion leaves the result and the flag untouched.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After reset, busy, flag, hold, result and DAC code are all 0.
- R2: The divide ratio depends on the select code as follows: 000→2, 100→4, 001→8, 101→16, 010→32, 110→64. With ratio N, busy falls exactly 11·N clock edges after the edge that samples the start request.
- R3: Any select code whose low two bits are 11 uses the synchronised rising edges of the RC clock as ticks. With an RC period of 8 system clocks, the conversion completes between 80 and 92 edges after the start.
- R4: Hold stays 0 until the first tick (N edges after the start). It is 1 during the ten periods that follow, and it returns to 0 when busy falls. Hold is never 1 while busy is 0.
- R5: In bit period p (p = 1..8), the DAC code equals the bits already decided, with bit 8−p set to 1 and all lower bits at 0. The bit is kept when the comparator is 1 (input ≥ trial). Outside the bit periods the DAC code is 0. The final result equals the input level.
- R6: On the edge that ends the last period, the result register loads, busy goes to 0 and the flag goes to 1, all together.
- R7: Clearing the start bit while busy ends the conversion on the next edge. The result is left unchanged, the flag is left unchanged and hold is released.
- R8: The flag is sticky. A new start leaves it alone, and the flag-clear input resets it. If a completion and a flag clear occur on the same edge, the set wins.
- R9: The select code is captured at the start. Changing it during a conversion does not alter that conversion's timing.
- R10: A start request while busy is ignored. It does not restart the frame or change the timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cfg_sel_i | input | 3 | Conversion clock select code |
| go_set_i | input | 1 | Pulse: software sets the start bit |
| go_clr_i | input | 1 | Pulse: software clears the start bit (abort) |
| flag_clr_i | input | 1 | Pulse: software clears the done flag |
| rc_clk_i | input | 1 | Asynchronous RC conversion clock |
| cmp_i | input | 1 | Comparator: 1 when input ≥ DAC level |
| busy_o | output | 1 | Start/busy bit readback |
| flag_o | output | 1 | Sticky conversion-done flag |
| result_o | output | 8 | Result register |
| hold_o | output | 1 | Sample capacitor disconnect |
| dac_code_o | output | 8 | Trial code to the DAC |

## Verification
With the system-clock sources, a result is due exactly 11·N edges after the start edge. The hold rises after N edges, and the DAC code steps every N edges after that. The bench stamps each expected result with the cycle of its start edge, and the monitor demands that exact latency when busy falls. With the RC source, the unknown synchroniser phase allows only a window, so the check accepts the range given in R3. Per-period probes of hold and of the DAC code, and of the flag around a completion, are taken at falling edges a counted number of cycles after the start.

// File: rtl/sar_conv_pkg.sv
package sar_conv_pkg;

  typedef enum logic [1:0] {
    CV_IDLE  = 2'd0,
    CV_ALIGN = 2'd1,
    CV_RUN   = 2'd2
  } cv_state_t;

  // Low two bits both set route the RC clock in.
  function automatic logic sel_is_rc(input logic [2:0] sel);
    return sel[1:0] == 2'b11;
  endfunction

  // log2 of the divide ratio: bit 2 adds one, bits 1:0 add two per step.
  function automatic logic [2:0] sel_div_log2(input logic [2:0] sel);
    return 3'd1 + {2'b00, sel[2]} + {sel[1:0], 1'b0};
  endfunction

endpackage

// File: rtl/sar_tad_gen.sv
module sar_tad_gen import sar_conv_pkg::*; #(
  parameter int CNT_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart_i,
  input  logic [2:0] sel_i,
  input  logic       rc_clk_i,
  output logic       tick_o
);

  logic [CNT_W-1:0]     cnt_q;
  logic [CNT_W-1:0]     limit;
  logic                 sys_tick;
  logic [SYNC_STAGES:0] rc_sh_q;
  logic                 rc_tick;

  always_comb begin
    limit    = CNT_W'((32'd1 << sel_div_log2(sel_i)) - 32'd1);
    sys_tick = (cnt_q == limit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart_i || sys_tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // Synchroniser chain plus one delayed copy for edge detection.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rc_sh_q <= '0;
    end else begin
      rc_sh_q <= {rc_sh_q[SYNC_STAGES-1:0], rc_clk_i};
    end
  end

  assign rc_tick = rc_sh_q[SYNC_STAGES-1] & ~rc_sh_q[SYNC_STAGES];
  assign tick_o  = sel_is_rc(sel_i) ? rc_tick : sys_tick;

endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine #(
  parameter int RES_W = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             step_i,
  input  logic             bit_active_i,
  input  logic [IDX_W-1:0] bit_idx_i,
  input  logic             cmp_i,
  output logic [RES_W-1:0] code_o,
  output logic [RES_W-1:0] dac_o
);

  logic [RES_W-1:0] code_q;
  logic [RES_W-1:0] trial;

  function automatic logic [RES_W-1:0] trial_code(input logic [RES_W-1:0] decided,
                                                  input logic [IDX_W-1:0] idx);
    logic [RES_W-1:0] one;
    one = '0;
    one[idx] = 1'b1;
    return decided | one;
  endfunction

  assign trial = trial_code(code_q, bit_idx_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
    end else if (clear_i) begin
      code_q <= '0;
    end else if (step_i && cmp_i) begin
      code_q <= trial;
    end
  end

  assign code_o = code_q;
  assign dac_o  = bit_active_i ? trial : '0;

endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl import sar_conv_pkg::*; #(
  parameter int RES_W        = 8,
  parameter int MAX_DIV_LOG2 = 6,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       cfg_sel_i,
  input  logic             go_set_i,
  input  logic             go_clr_i,
  input  logic             flag_clr_i,
  input  logic             rc_clk_i,
  input  logic             cmp_i,
  output logic             busy_o,
  output logic             flag_o,
  output logic [RES_W-1:0] result_o,
  output logic             hold_o,
  output logic [RES_W-1:0] dac_code_o
);

  localparam int LAST_PER = RES_W + 1;
  localparam int PER_W    = $clog2(LAST_PER + 1);
  localparam int IDX_W    = (RES_W > 1) ? $clog2(RES_W) : 1;

  cv_state_t        st_q;
  logic [PER_W-1:0] per_q;
  logic [2:0]       sel_q;
  logic [RES_W-1:0] result_q;
  logic             flag_q;

  // Named events for the checker.
  logic             tad_tick;
  logic             start_evt;
  logic             abort_evt;
  logic             done_evt;
  logic             bit_period;
  logic             bit_step;
  logic [IDX_W-1:0] bit_idx;
  logic [RES_W-1:0] code_w;

  always_comb begin
    start_evt  = (st_q == CV_IDLE) && go_set_i && !go_clr_i;
    abort_evt  = (st_q != CV_IDLE) && go_clr_i;
    bit_period = (st_q == CV_RUN) && (per_q != '0) && (per_q <= PER_W'(RES_W));
    bit_idx    = IDX_W'(PER_W'(RES_W) - per_q);
    bit_step   = bit_period && tad_tick;
    done_evt   = (st_q == CV_RUN) && tad_tick && (per_q == PER_W'(LAST_PER)) && !go_clr_i;
  end

  sar_tad_gen #(
    .CNT_W       (MAX_DIV_LOG2),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_tad (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (start_evt),
    .sel_i     (sel_q),
    .rc_clk_i  (rc_clk_i),
    .tick_o    (tad_tick)
  );

  sar_bit_engine #(
    .RES_W (RES_W),
    .IDX_W (IDX_W)
  ) u_bits (
    .clk          (clk),
    .rst_n        (rst_n),
    .clear_i      (start_evt),
    .step_i       (bit_step),
    .bit_active_i (bit_period),
    .bit_idx_i    (bit_idx),
    .cmp_i        (cmp_i),
    .code_o       (code_w),
    .dac_o        (dac_code_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= CV_IDLE;
      per_q    <= '0;
      sel_q    <= '0;
      result_q <= '0;
      flag_q   <= 1'b0;
    end else begin
      case (st_q)
        CV_IDLE: begin
          if (start_evt) begin
            st_q  <= CV_ALIGN;
            sel_q <= cfg_sel_i;
            per_q <= '0;
          end
        end
        CV_ALIGN: begin
          if (abort_evt) begin
            st_q <= CV_IDLE;
          end else if (tad_tick) begin
            st_q  <= CV_RUN;
            per_q <= '0;
          end
        end
        CV_RUN: begin
          if (abort_evt) begin
            st_q <= CV_IDLE;
          end else if (tad_tick) begin
            if (per_q == PER_W'(LAST_PER)) begin
              st_q     <= CV_IDLE;
              result_q <= code_w;
            end else begin
              per_q <= per_q + 1'b1;
            end
          end
        end
        default: st_q <= CV_IDLE;
      endcase

      if (done_evt) begin
        flag_q <= 1'b1;
      end else if (flag_clr_i) begin
        flag_q <= 1'b0;
      end
    end
  end

  assign busy_o   = (st_q != CV_IDLE);
  assign hold_o   = (st_q == CV_RUN);
  assign flag_o   = flag_q;
  assign result_o = result_q;

endmodule

// File: rtl/sar_conv_chk.sv
module sar_conv_chk #(
  parameter int RES_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             go_clr_i,
  input logic             busy_o,
  input logic             flag_o,
  input logic             hold_o,
  input logic [RES_W-1:0] result_o,
  input logic [RES_W-1:0] dac_code_o,
  input logic             tad_tick
);

  // R4
  hold_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_o |-> busy_o);

  // R6
  flag_rise_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o) |-> $fell(busy_o));

  // R6
  done_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_o) && !$past(go_clr_i)) |-> flag_o);

  // R7
  abort_keeps_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_o) && $past(go_clr_i)) |-> $stable(result_o));

  // R5
  result_only_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result_o) |-> $fell(busy_o));

  // R5
  dac_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_code_o != '0) |-> hold_o);

  // R2
  dac_steps_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_o && $past(hold_o) && !$stable(dac_code_o)) |-> $past(tad_tick));

endmodule

bind sar_conv_ctrl sar_conv_chk #(.RES_W(RES_W)) u_sar_conv_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .go_clr_i   (go_clr_i),
  .busy_o     (busy_o),
  .flag_o     (flag_o),
  .hold_o     (hold_o),
  .result_o   (result_o),
  .dac_code_o (dac_code_o),
  .tad_tick   (tad_tick)
);

// File: tb/test_sar_conv_ctrl.sv
module test_sar_conv_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cfg_sel = 3'b000;
  logic       go_set = 1'b0;
  logic       go_clr = 1'b0;
  logic       flag_clr = 1'b0;
  logic       rc_clk = 1'b0;
  logic       cmp;
  logic       busy, flag, hold;
  logic [7:0] result, dac_code;
  logic [7:0] vin = 8'h00;

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;
  bit prev_busy = 1'b0;

  typedef struct {
    bit         aborted;
    logic [7:0] res;
    bit         flg;
    int         lo;
    int         hi;
    int         t0;
    string      req;
  } exp_t;

  exp_t sb[$];
  exp_t e;

  sar_conv_ctrl i_sar_conv_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_sel_i  (cfg_sel),
    .go_set_i   (go_set),
    .go_clr_i   (go_clr),
    .flag_clr_i (flag_clr),
    .rc_clk_i   (rc_clk),
    .cmp_i      (cmp),
    .busy_o     (busy),
    .flag_o     (flag),
    .result_o   (result),
    .hold_o     (hold),
    .dac_code_o (dac_code)
  );

  // Comparator and DAC model.
  assign cmp = (vin >= dac_code);

  initial forever #10 clk = ~clk;
  initial begin
    #3;
    forever #80 rc_clk = ~rc_clk;
  end

  function automatic int ratio_of(input logic [2:0] s);
    case (s)
      3'b000:  return 2;
      3'b100:  return 4;
      3'b001:  return 8;
      3'b101:  return 16;
      3'b010:  return 32;
      3'b110:  return 64;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Driver: starts a conversion and pushes the expected outcome.
  task automatic kick(input logic [2:0] s, input logic [7:0] v, input int lo, input int hi,
                      input bit flg, input bit abrt, input logic [7:0] res, input string req);
    exp_t it;
    @(negedge clk);
    cfg_sel = s;
    vin     = v;
    go_set  = 1'b1;
    it.aborted = abrt;
    it.res     = res;
    it.flg     = flg;
    it.lo      = lo;
    it.hi      = hi;
    it.t0      = cyc + 1;
    it.req     = req;
    sb.push_back(it);
    @(negedge clk);
    go_set = 1'b0;
  endtask

  task automatic wait_idle;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  // Cycle count and watchdog.
  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000) begin
      n_bad++;
      $display("FAIL watchdog R1..: actual %0d expected below %0d", cyc, 60000);
      summary();
      $finish;
    end
  end

  // Monitor: pops an expected item when busy falls.
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_busy && !busy) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R6 unexpected end", 1, 0);
        end else begin
          e = sb.pop_front();
          chk(result == e.res, {e.req, " result"}, result, e.res);
          chk(flag == e.flg, {e.req, " flag"}, flag, e.flg);
          chk(hold == 1'b0, "R4 hold released", hold, 0);
          if (!e.aborted)
            chk((cyc - e.t0) >= e.lo && (cyc - e.t0) <= e.hi, {e.req, " latency"},
                cyc - e.t0, e.lo);
        end
      end
      prev_busy = busy;
    end
  end

  initial begin
    logic [2:0] codes [6];
    logic [7:0] levels [6];
    codes  = '{3'b000, 3'b100, 3'b001, 3'b101, 3'b010, 3'b110};
    levels = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h80, 8'h7F};

    wait_neg(5);
    // R1 reset state
    chk(busy == 0 && flag == 0 && hold == 0, "R1 status", {busy, flag, hold}, 0);
    chk(result == 8'h00 && dac_code == 8'h00, "R1 data", {result, dac_code}, 0);
    rst_n = 1'b1;
    wait_neg(2);

    // R2 every divider code, R5 several input levels
    for (int i = 0; i < 6; i++) begin
      kick(codes[i], levels[i], 11 * ratio_of(codes[i]), 11 * ratio_of(codes[i]),
           1'b1, 1'b0, levels[i], "R2");
      wait_idle();
    end

    // R4/R5 per-period trace with ratio 2, level 5A
    kick(3'b000, 8'h5A, 22, 22, 1'b1, 1'b0, 8'h5A, "R5");
    wait_neg(1);   // after start edge + 1
    chk(hold == 0, "R4 hold before first tick", hold, 0);
    wait_neg(1);   // +2: TAD0
    chk(hold == 1, "R4 hold in TAD0", hold, 1);
    chk(dac_code == 8'h00, "R5 dac idle in TAD0", dac_code, 0);
    wait_neg(2);   // +4: first bit
    chk(dac_code == 8'h80, "R5 msb trial", dac_code, 8'h80);
    wait_neg(2);
    chk(dac_code == 8'h40, "R5 second trial", dac_code, 8'h40);
    wait_neg(2);
    chk(dac_code == 8'h60, "R5 third trial", dac_code, 8'h60);
    wait_neg(2);
    chk(dac_code == 8'h50, "R5 fourth trial", dac_code, 8'h50);
    wait_idle();

    // R3 RC clock, both codes ending in 11
    kick(3'b011, 8'hC3, 80, 92, 1'b1, 1'b0, 8'hC3, "R3");
    wait_idle();
    kick(3'b111, 8'h01, 80, 92, 1'b1, 1'b0, 8'h01, "R3");
    wait_idle();

    // R9 select change mid-conversion
    kick(3'b100, 8'h99, 44, 44, 1'b1, 1'b0, 8'h99, "R9");
    wait_neg(5);
    cfg_sel = 3'b110;
    wait_idle();

    // R10 start while busy ignored
    kick(3'b000, 8'h66, 22, 22, 1'b1, 1'b0, 8'h66, "R10");
    wait_neg(7);
    go_set = 1'b1;
    wait_neg(1);
    go_set = 1'b0;
    wait_idle();
    chk(busy == 0, "R10 no second frame", busy, 0);

    // R8 sticky flag across a new start, then clear
    kick(3'b101, 8'h11, 176, 176, 1'b1, 1'b0, 8'h11, "R8");
    wait_neg(3);
    chk(flag == 1, "R8 flag kept at start", flag, 1);
    wait_idle();
    flag_clr = 1'b1;
    wait_neg(1);
    flag_clr = 1'b0;
    chk(flag == 0, "R8 flag cleared", flag, 0);

    // R8 set wins over a same-edge clear (completion at start edge + 22)
    kick(3'b000, 8'h3C, 22, 22, 1'b1, 1'b0, 8'h3C, "R8 set wins");
    wait_neg(21);
    flag_clr = 1'b1;
    wait_neg(1);
    flag_clr = 1'b0;
    wait_idle();

    flag_clr = 1'b1;
    wait_neg(1);
    flag_clr = 1'b0;

    // R7 abort keeps result 3C and flag 0
    kick(3'b001, 8'hF0, 0, 100000, 1'b0, 1'b1, 8'h3C, "R7");
    wait_neg(20);
    chk(hold == 1, "R7 running before abort", hold, 1);
    go_clr = 1'b1;
    wait_neg(1);
    go_clr = 1'b0;
    chk(busy == 0 && hold == 0, "R7 stopped", {busy, hold}, 0);
    wait_neg(3);
    chk(result == 8'h3C && flag == 0, "R7 untouched", {result, flag}, {8'h3C, 1'b0});

    // Recovery after abort
    kick(3'b000, 8'hE7, 22, 22, 1'b1, 1'b0, 8'hE7, "R6");
    wait_idle();

    chk(sb.size() == 0, "R6 all results seen", sb.size(), 0);
    summary();
    $finish;
  end

endmodule